// File: doc/BRIEF.md
# LCD Panel Sync Timing Generator

This block produces the raster timing for a flat panel: a pixel-rate enable and pixel clock level, a line sync, a frame sync, a data-enable window, the current column and row inside the visible area, and a slow mode toggle used by passive panels to alternate drive polarity. Everything is derived from the core clock and a set of static configuration fields. The pixel rate is the core clock divided by an even ratio, or the core clock itself when the divider is bypassed.

The horizontal and vertical timing fields use different encodings. Every horizontal field (sync pulse, back porch, front porch) holds its length minus one. The vertical sync pulse holds its length minus one, while the vertical porches hold plain line counts, so either porch may be zero. The visible height is programmed minus one. The visible width is not programmed directly: for active-matrix (TFT) panels it is the pixel count, and for passive (STN) panels the block turns the pixel count into a number of data shift clocks per line, based on colour type, data bus width and scan mode.

Configuration is assumed stable while `enable` is high. Dropping `enable` returns all counters and the mode output to their start state. Fetching pixel data and panel power sequencing are handled elsewhere.

Top module: `lcd_sync_gen`

## Requirements
- R1: With the bypass bit clear and divider value N, `pix_en` is high for one core cycle in every 2(N+1). Counting core cycles c from 0 at the first cycle `enable` is high, `pix_en` is high when c mod 2(N+1) equals 2N+1, and `pix_clk` equals (c div (N+1)) mod 2.
- R2: With the bypass bit set, `pix_en` is high on every enabled core cycle and `pix_clk` stays low.
- R3: For a TFT panel (`cfg_stn`=0), `line_clks` equals `cfg_xres`.
- R4: For an STN panel, `line_clks` is computed as follows. The pixel count is tripled when `cfg_color`=1. The result is then divided by 4, rounding up, when `cfg_bus`=0 (4-bit bus) or when `cfg_bus`=1 (8-bit bus) with `cfg_dual`=1. In every other case (`cfg_bus` 1 single scan, 2 or 3) it is divided by 8, rounding up.
- R5: A line lasts (hpw+1)+(hbp+1)+line_clks+(hfp+1) pixel ticks, in this order: sync, back porch, visible, front porch. The line sync is active during the first hpw+1 ticks.
- R6: A frame lasts (vpw+1)+vbp+(vact+1)+vfp lines, in this order: sync, back porch, visible, front porch. Both porches are raw counts. The frame sync is active during the first vpw+1 lines.
- R7: `de` is high only when both the column and the row are inside the visible region. `x_pos` and `y_pos` give the offset into the visible columns and rows, and each is 0 outside its own visible region.
- R8: `hsync` and `vsync` are active high when `cfg_inv_hs` and `cfg_inv_vs` are 0. Each output is inverted when its bit is 1.
- R9: `lcd_mode` starts at 0 and toggles at the end of every M+1 frames, where M is `cfg_mode_val`. M=0 toggles it every frame.
- R10: While `enable` is low, `pix_en` and `de` are low and both syncs sit at their inactive level. One clock after `enable` is low, `lcd_mode`, `x_pos` and `y_pos` are 0, and the next enable starts again from the first pixel of the first line.
- R11: Column and row counters advance only on cycles where `pix_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the timing generator |
| cfg_clk_div | input | DIV_W | Divider value N, pixel rate = clk / 2(N+1) |
| cfg_bypass | input | 1 | Use the core clock rate undivided |
| cfg_stn | input | 1 | 1 = passive (STN) panel, 0 = TFT |
| cfg_color | input | 1 | STN colour panel (three subpixels per pixel) |
| cfg_bus | input | 2 | STN data bus: 0 = 4-bit, 1 = 8-bit, 2/3 = 16-bit |
| cfg_dual | input | 1 | STN dual-scan mode |
| cfg_xres | input | H_W | Horizontal resolution in pixels |
| cfg_vact_m1 | input | V_W | Visible lines minus one |
| cfg_hpw_m1 | input | T_W | Line sync width minus one |
| cfg_hbp_m1 | input | T_W | Horizontal back porch minus one |
| cfg_hfp_m1 | input | T_W | Horizontal front porch minus one |
| cfg_vpw_m1 | input | T_W | Frame sync width in lines minus one |
| cfg_vbp | input | T_W | Vertical back porch in lines |
| cfg_vfp | input | T_W | Vertical front porch in lines |
| cfg_inv_hs | input | 1 | Invert line sync polarity |
| cfg_inv_vs | input | 1 | Invert frame sync polarity |
| cfg_mode_val | input | MODE_W | Mode toggle interval minus one, in frames |
| pix_en | output | 1 | Pixel tick, one core cycle wide |
| pix_clk | output | 1 | Divided pixel clock level |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| de | output | 1 | Data enable |
| x_pos | output | H_W+2 | Column inside the visible area |
| y_pos | output | V_W | Row inside the visible area |
| line_clks | output | H_W+2 | Shift clocks (pixel ticks) per visible line |
| lcd_mode | output | 1 | Frame-rate mode toggle |

## Verification
The hardest part to reach is the mode toggle with an interval greater than one frame. It needs several complete frames to pass, each with many pixel ticks and each tick costing 2(N+1) core cycles. The stimulus therefore uses tiny rasters with only a handful of pixels and lines, zero-length vertical porches, minimal divider values and the bypass mode, so that up to nine frames run in a few hundred cycles. For each cycle the bench works out the expected tick count, column, row, frame number and mode level by plain division from the cycle count. Shift-clock widths are swept over every panel-type, bus and scan-mode combination for resolutions from 1 to 64.

// File: rtl/lcdt_pkg.sv
// Shared types for the LCD sync timing generator.
package lcdt_pkg;
    // Data bus width selector for passive panels; 2 and 3 both mean 16 bits.
    typedef enum logic [1:0] {
        BUS_4B  = 2'd0,
        BUS_8B  = 2'd1,
        BUS_16B = 2'd2,
        BUS_16C = 2'd3
    } bus_w_e;

    // Decoded position of one raster axis.
    typedef struct packed {
        logic sync;    // inside the sync pulse
        logic active;  // inside the visible span
        logic last;    // final count of the axis period
    } axis_state_t;
endpackage

// File: rtl/lcdt_pix_div.sv
// Pixel-rate generator: divides the core clock by 2(N+1), or passes
// every cycle when bypassed. Assumes the divider value is static while run.
module lcdt_pix_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             bypass,
    input  logic [DIV_W-1:0] div_val,
    output logic             pix_en,
    output logic             pix_clk
);
    logic [DIV_W-1:0] cnt_q;
    logic             phase_q;

    // Half-period counter and clock phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || bypass) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (cnt_q == div_val) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // One tick per full period, at the end of the high phase.
    always_comb begin
        pix_en  = run && (bypass || (phase_q && (cnt_q == div_val)));
        pix_clk = phase_q;
    end
endmodule

// File: rtl/lcdt_line_width.sv
// Computes the number of pixel ticks in the visible part of a line.
// TFT: one tick per pixel. STN: subpixels packed 4 or 8 per tick.
module lcdt_line_width
    import lcdt_pkg::*;
#(
    parameter int H_W = 10,
    localparam int HOZ_W = H_W + 2
) (
    input  logic             stn,
    input  logic             color,
    input  logic [1:0]       bus,
    input  logic             dual,
    input  logic [H_W-1:0]   xres,
    output logic [HOZ_W-1:0] line_clks
);
    logic [HOZ_W-1:0] scaled;
    logic             quad;

    // Subpixel count, then round-up division by the bus packing.
    always_comb begin
        scaled = color ? (HOZ_W'(xres) + (HOZ_W'(xres) << 1)) : HOZ_W'(xres);
        quad   = (bus == BUS_4B) || ((bus == BUS_8B) && dual);
        if (!stn)
            line_clks = HOZ_W'(xres);
        else if (quad)
            line_clks = (scaled + HOZ_W'(3)) >> 2;
        else
            line_clks = (scaled + HOZ_W'(7)) >> 3;
    end
endmodule

// File: rtl/lcdt_axis.sv
// One raster axis: counts steps through sync, back porch, visible span
// and front porch (all given as raw lengths), wrapping after the total.
// Assumes sync_len >= 1 and the lengths are static while counting.
module lcdt_axis
    import lcdt_pkg::*;
#(
    parameter int CW = 12,
    parameter int LW = 7,
    parameter int OW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [LW-1:0] sync_len,
    input  logic [LW-1:0] bp_len,
    input  logic [CW-1:0] act_len,
    input  logic [LW-1:0] fp_len,
    output axis_state_t   st,
    output logic [OW-1:0] offs
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] total;
    logic [CW-1:0] a_start;
    logic [CW-1:0] a_end;

    // Segment boundaries.
    always_comb begin
        a_start = CW'(sync_len) + CW'(bp_len);
        a_end   = a_start + act_len;
        total   = a_end + CW'(fp_len);
    end

    // Decode of the current count.
    always_comb begin
        st.sync   = cnt_q < CW'(sync_len);
        st.active = (cnt_q >= a_start) && (cnt_q < a_end);
        st.last   = cnt_q == (total - CW'(1));
        offs      = st.active ? OW'(cnt_q - a_start) : '0;
    end

    // Position counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (step)
            cnt_q <= st.last ? '0 : cnt_q + CW'(1);
    end
endmodule

// File: rtl/lcdt_mode_flip.sv
// Toggles the mode output once every (mode_val + 1) completed frames.
module lcdt_mode_flip #(
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              frame_end,
    input  logic [MODE_W-1:0] mode_val,
    output logic              mode_q
);
    logic [MODE_W-1:0] fcnt_q;

    // Frame counter and toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            fcnt_q <= '0;
            mode_q <= 1'b0;
        end else if (frame_end) begin
            if (fcnt_q == mode_val) begin
                fcnt_q <= '0;
                mode_q <= ~mode_q;
            end else begin
                fcnt_q <= fcnt_q + MODE_W'(1);
            end
        end
    end
endmodule

// File: rtl/lcd_sync_gen.sv
// LCD panel sync timing generator top. Converts the mixed minus-one
// register encodings to raw lengths, drives the horizontal and vertical
// axes from the pixel tick and forms the panel control outputs.
// Assumes all cfg_* inputs are static while enable is high.
module lcd_sync_gen
    import lcdt_pkg::*;
#(
    parameter int H_W    = 10,
    parameter int V_W    = 10,
    parameter int T_W    = 6,
    parameter int DIV_W  = 8,
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DIV_W-1:0]  cfg_clk_div,
    input  logic              cfg_bypass,
    input  logic              cfg_stn,
    input  logic              cfg_color,
    input  logic [1:0]        cfg_bus,
    input  logic              cfg_dual,
    input  logic [H_W-1:0]    cfg_xres,
    input  logic [V_W-1:0]    cfg_vact_m1,
    input  logic [T_W-1:0]    cfg_hpw_m1,
    input  logic [T_W-1:0]    cfg_hbp_m1,
    input  logic [T_W-1:0]    cfg_hfp_m1,
    input  logic [T_W-1:0]    cfg_vpw_m1,
    input  logic [T_W-1:0]    cfg_vbp,
    input  logic [T_W-1:0]    cfg_vfp,
    input  logic              cfg_inv_hs,
    input  logic              cfg_inv_vs,
    input  logic [MODE_W-1:0] cfg_mode_val,
    output logic              pix_en,
    output logic              pix_clk,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [H_W+1:0]    x_pos,
    output logic [V_W-1:0]    y_pos,
    output logic [H_W+1:0]    line_clks,
    output logic              lcd_mode
);
    localparam int HOZ_W  = H_W + 2;
    localparam int LW     = T_W + 1;
    localparam int HCNT_W = HOZ_W + 2;
    localparam int VCNT_W = V_W + 2;

    axis_state_t       h_st, v_st;
    logic [LW-1:0]     h_sync_len, h_bp_len, h_fp_len;
    logic [LW-1:0]     v_sync_len, v_bp_len, v_fp_len;
    logic [HCNT_W-1:0] h_act_len;
    logic [VCNT_W-1:0] v_act_len;
    logic              line_end, frame_end;

    lcdt_pix_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (enable),
        .bypass  (cfg_bypass),
        .div_val (cfg_clk_div),
        .pix_en  (pix_en),
        .pix_clk (pix_clk)
    );

    lcdt_line_width #(.H_W(H_W)) u_width (
        .stn       (cfg_stn),
        .color     (cfg_color),
        .bus       (cfg_bus),
        .dual      (cfg_dual),
        .xres      (cfg_xres),
        .line_clks (line_clks)
    );

    // Field decode: horizontal fields all minus one, vertical porches raw.
    always_comb begin
        h_sync_len = LW'(cfg_hpw_m1) + LW'(1);
        h_bp_len   = LW'(cfg_hbp_m1) + LW'(1);
        h_fp_len   = LW'(cfg_hfp_m1) + LW'(1);
        h_act_len  = HCNT_W'(line_clks);
        v_sync_len = LW'(cfg_vpw_m1) + LW'(1);
        v_bp_len   = LW'(cfg_vbp);
        v_fp_len   = LW'(cfg_vfp);
        v_act_len  = VCNT_W'(cfg_vact_m1) + VCNT_W'(1);
    end

    // Line and frame boundaries, both on a pixel tick.
    always_comb begin
        line_end  = pix_en && h_st.last;
        frame_end = line_end && v_st.last;
    end

    lcdt_axis #(.CW(HCNT_W), .LW(LW), .OW(HOZ_W)) u_h_axis (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!enable),
        .step     (pix_en),
        .sync_len (h_sync_len),
        .bp_len   (h_bp_len),
        .act_len  (h_act_len),
        .fp_len   (h_fp_len),
        .st       (h_st),
        .offs     (x_pos)
    );

    lcdt_axis #(.CW(VCNT_W), .LW(LW), .OW(V_W)) u_v_axis (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!enable),
        .step     (line_end),
        .sync_len (v_sync_len),
        .bp_len   (v_bp_len),
        .act_len  (v_act_len),
        .fp_len   (v_fp_len),
        .st       (v_st),
        .offs     (y_pos)
    );

    lcdt_mode_flip #(.MODE_W(MODE_W)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (enable),
        .frame_end (frame_end),
        .mode_val  (cfg_mode_val),
        .mode_q    (lcd_mode)
    );

    // Panel control outputs with programmable sync polarity.
    always_comb begin
        hsync = (enable && h_st.sync) ^ cfg_inv_hs;
        vsync = (enable && v_st.sync) ^ cfg_inv_vs;
        de    = enable && h_st.active && v_st.active;
    end
endmodule

// File: rtl/lcd_sync_gen_chk.sv
// Property checker for lcd_sync_gen, attached by bind below.
module lcd_sync_gen_chk #(
    parameter int H_W = 10,
    localparam int HOZ_W = H_W + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             cfg_bypass,
    input logic             cfg_inv_hs,
    input logic             pix_en,
    input logic             hsync,
    input logic             de,
    input logic [HOZ_W-1:0] x_pos,
    input logic [HOZ_W-1:0] line_clks,
    input logic             lcd_mode
);
    // R1
    divided_tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_bypass && pix_en) |=> !pix_en);

    // R7
    de_column_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (x_pos < line_clks));

    // R5
    de_outside_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (hsync == cfg_inv_hs));

    // R9
    mode_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !pix_en) |=> $stable(lcd_mode));

    // R10
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (lcd_mode == 1'b0 && x_pos == '0));
endmodule

bind lcd_sync_gen lcd_sync_gen_chk #(.H_W(H_W)) i_lcd_sync_gen_chk (.*);

// File: tb/test_lcd_sync_gen.sv
module test_lcd_sync_gen;
    localparam int CLK_P  = 10;
    localparam int H_W    = 10;
    localparam int V_W    = 10;
    localparam int T_W    = 6;
    localparam int DIV_W  = 8;
    localparam int MODE_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [DIV_W-1:0] cfg_clk_div = '0;
    logic cfg_bypass = 1'b0, cfg_stn = 1'b0, cfg_color = 1'b0, cfg_dual = 1'b0;
    logic [1:0] cfg_bus = '0;
    logic [H_W-1:0] cfg_xres = '0;
    logic [V_W-1:0] cfg_vact_m1 = '0;
    logic [T_W-1:0] cfg_hpw_m1 = '0, cfg_hbp_m1 = '0, cfg_hfp_m1 = '0;
    logic [T_W-1:0] cfg_vpw_m1 = '0, cfg_vbp = '0, cfg_vfp = '0;
    logic cfg_inv_hs = 1'b0, cfg_inv_vs = 1'b0;
    logic [MODE_W-1:0] cfg_mode_val = '0;
    logic pix_en, pix_clk, hsync, vsync, de, lcd_mode;
    logic [H_W+1:0] x_pos, line_clks;
    logic [V_W-1:0] y_pos;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    lcd_sync_gen #(.H_W(H_W), .V_W(V_W), .T_W(T_W), .DIV_W(DIV_W), .MODE_W(MODE_W))
    i_lcd_sync_gen (.*);

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_hoz(int x, bit stn, bit col, int bus, bit dual);
        int s;
        if (!stn) return x;
        s = col ? 3 * x : x;
        if (bus == 0 || (bus == 1 && dual)) return (s + 3) / 4;
        return (s + 7) / 8;
    endfunction

    // Run one configuration for n cycles, predicting every output per cycle.
    task automatic run_cfg(int n, int xr, bit stn, bit col, int bus, bit dual,
                           int hpw, int hbp, int hfp, int vpw, int vbp, int vfp,
                           int vact, int dv, bit byp, bit ihs, bit ivs, int mv);
        int hoz, htot, vtot, fr, per, t, f, r, h, v, hst, vst;
        bit ha, va;
        @(negedge clk);
        enable = 1'b0;
        cfg_xres = H_W'(xr); cfg_stn = stn; cfg_color = col; cfg_bus = 2'(bus);
        cfg_dual = dual; cfg_hpw_m1 = T_W'(hpw); cfg_hbp_m1 = T_W'(hbp);
        cfg_hfp_m1 = T_W'(hfp); cfg_vpw_m1 = T_W'(vpw); cfg_vbp = T_W'(vbp);
        cfg_vfp = T_W'(vfp); cfg_vact_m1 = V_W'(vact); cfg_clk_div = DIV_W'(dv);
        cfg_bypass = byp; cfg_inv_hs = ihs; cfg_inv_vs = ivs;
        cfg_mode_val = MODE_W'(mv);
        repeat (3) @(negedge clk);
        hoz  = exp_hoz(xr, stn, col, bus, dual);
        htot = (hpw + 1) + (hbp + 1) + hoz + (hfp + 1);
        vtot = (vpw + 1) + vbp + (vact + 1) + vfp;
        fr   = htot * vtot;
        per  = byp ? 1 : 2 * (dv + 1);
        hst  = hpw + hbp + 2;
        vst  = vpw + 1 + vbp;
        enable = 1'b1;
        for (int c = 0; c < n; c++) begin
            #1;
            t  = byp ? c : c / per;
            f  = t / fr;
            r  = t % fr;
            h  = r % htot;
            v  = r / htot;
            ha = (h >= hst) && (h < hst + hoz);
            va = (v >= vst) && (v < vst + vact + 1);
            if (byp) begin
                chk(pix_en == 1'b1, "R2 pix_en", int'(pix_en), 1);
                chk(pix_clk == 1'b0, "R2 pix_clk", int'(pix_clk), 0);
            end else begin
                chk(pix_en == ((c % per) == per - 1), "R1 pix_en", int'(pix_en),
                    int'((c % per) == per - 1));
                chk(pix_clk == bit'((c / (dv + 1)) % 2), "R1 pix_clk",
                    int'(pix_clk), (c / (dv + 1)) % 2);
            end
            chk(hsync == ((h < hpw + 1) ^ ihs), "R5 R8 hsync", int'(hsync),
                int'((h < hpw + 1) ^ ihs));
            chk(vsync == ((v < vpw + 1) ^ ivs), "R6 R8 vsync", int'(vsync),
                int'((v < vpw + 1) ^ ivs));
            chk(de == (ha && va), "R7 de", int'(de), int'(ha && va));
            chk(int'(x_pos) == (ha ? h - hst : 0), "R7 R11 x_pos", int'(x_pos),
                ha ? h - hst : 0);
            chk(int'(y_pos) == (va ? v - vst : 0), "R7 R11 y_pos", int'(y_pos),
                va ? v - vst : 0);
            chk(lcd_mode == bit'((f / (mv + 1)) % 2), "R9 lcd_mode",
                int'(lcd_mode), (f / (mv + 1)) % 2);
            @(negedge clk);
        end
        // R10: disable returns to the idle state
        enable = 1'b0;
        #1;
        chk(pix_en == 1'b0, "R10 pix_en", int'(pix_en), 0);
        chk(de == 1'b0, "R10 de", int'(de), 0);
        chk(hsync == ihs, "R10 hsync", int'(hsync), int'(ihs));
        chk(vsync == ivs, "R10 vsync", int'(vsync), int'(ivs));
        @(negedge clk);
        #1;
        chk(lcd_mode == 1'b0, "R10 lcd_mode", int'(lcd_mode), 0);
        chk(x_pos == '0 && y_pos == '0, "R10 position", int'(x_pos) + int'(y_pos), 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        enable = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(lcd_mode == 1'b0, "R9 reset lcd_mode", int'(lcd_mode), 0);
        chk(de == 1'b0, "R7 reset de", int'(de), 0);
        chk(pix_clk == 1'b0, "R1 reset pix_clk", int'(pix_clk), 0);
        @(negedge clk);
        enable = 1'b0;
        rst_n = 1'b1;

        // R3 R4: sweep of shift-clock count over panel, bus and scan settings
        for (int x = 1; x <= 64; x++)
            for (int m = 0; m < 32; m++) begin
                @(negedge clk);
                cfg_xres = H_W'(x);
                cfg_stn = m[0]; cfg_color = m[1]; cfg_bus = m[3:2]; cfg_dual = m[4];
                #1;
                chk(int'(line_clks) == exp_hoz(x, m[0], m[1], int'(m[3:2]), m[4]),
                    m[0] ? "R4 line_clks" : "R3 line_clks", int'(line_clks),
                    exp_hoz(x, m[0], m[1], int'(m[3:2]), m[4]));
            end

        // TFT, divide by 4, toggle every frame
        run_cfg(760, 6, 0, 0, 0, 0, 1, 0, 2, 0, 1, 0, 2, 1, 0, 0, 0, 0);
        // STN colour 8-bit single scan, bypass, inverted syncs, every 3 frames
        run_cfg(220, 5, 1, 1, 1, 0, 0, 1, 0, 1, 0, 1, 1, 5, 1, 1, 1, 2);
        // STN mono 4-bit, divide by 8, zero back porch, every 2 frames
        run_cfg(1220, 10, 1, 0, 0, 0, 0, 0, 0, 0, 0, 2, 1, 3, 0, 1, 0, 1);
        // TFT, fastest divider, single visible line, every 4 frames
        run_cfg(520, 4, 0, 0, 2, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 1, 3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule